// File: doc/BRIEF.md
# FM Operator Phase Generator with Vibrato LFO

This block advances the phase of one FM operator once per sample and exposes the top bits of that phase as an index into a waveform table. The per-sample step comes from a 9-bit frequency number, a 3-bit octave, and a 4-bit multiplier code that goes through a fixed non-linear table. When vibrato is enabled for the operator, the step is scaled by an 8-bit-fraction factor that a slow sinusoidal LFO supplies. The same LFO section also runs a second, slower sinusoid whose value is a tremolo attenuation offset. An envelope stage outside this block consumes that offset.

The sample cadence comes from dividing the input clock by a parameter (72 by default). All state changes happen on the clock edge of that sample tick. The only exception is the key-triggered phase clear, which acts on any edge. Each update produces a one-cycle `sample_valid_o` pulse. The output has no back-pressure, because the sample rate is fixed and a consumer must take each sample in the cycle it is shown. Sine lookup, envelope and mixing sit downstream.

Top module: `fm_phase_gen`

## Requirements
- R1: While reset is held and just after it is released, the phase index is 0, the vibrato factor is 256, the tremolo offset is 6, and `sample_valid_o` is low.
- R2: A sample update happens on every DIV-th clock edge, with the first update on the DIV-th edge after reset release. `sample_valid_o` is high for exactly the one cycle that follows each update edge.
- R3: The step is ((fnum × M) << octave) >> 2, where M is taken from the multiplier code 0..15 as 1,2,4,6,8,10,12,14,16,18,20,20,24,24,30,30.
- R4: With vibrato disabled, each update adds the step to an 18-bit accumulator, which wraps modulo 2^18. Between updates, with no clear, the accumulator holds its value.
- R5: With vibrato enabled, each update adds (step × F) >> 8 instead, wrapping modulo 2^18. F is the vibrato factor that the same update puts on `vib_factor_o`.
- R6: The vibrato LFO is a 16-bit phase that advances by 8 per update, at the default rate. Its upper 8 bits k select F = trunc(256 × 2^(13.75 × sin(2πk/256) / 1200)).
- R7: The tremolo LFO is a 16-bit phase that advances by 4 per update, at the default rate. Its upper 8 bits k select trunc(6.4 × (1 + sin(2πk/256))).
- R8: `phase_idx_o` is bits 17..9 of the accumulator.
- R9: `key_clr_i` high at an edge forces the accumulator to 0 at that edge, and this takes priority over an update on the same edge. The LFOs are not affected.
- R10: Frequency, octave, multiplier and vibrato inputs are used only at update edges. Changing them between updates leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fnum_i | input | 9 | Frequency number |
| block_i | input | 3 | Octave shift |
| mult_i | input | 4 | Multiplier code |
| vib_en_i | input | 1 | Apply vibrato to this operator |
| key_clr_i | input | 1 | Clear phase accumulator (key-on) |
| sample_valid_o | output | 1 | One-cycle pulse after each update |
| phase_idx_o | output | 9 | Waveform table index |
| vib_factor_o | output | 9 | Current vibrato factor (256 = unity) |
| trem_o | output | 4 | Current tremolo offset |

## Verification
The bench drives the extremes of the step formula. It uses a step that truncates to zero (fnum 1, code 0), which a design that dropped the pre-shift would move. It uses the largest step at top octave and code 15, which must wrap the accumulator rather than saturate or carry into the index. It uses the duplicate codes 11 and 13, which a linear multiplier would get wrong. The bench sweeps the vibrato LFO past its positive peak, where an off-by-one lookup or a factor taken from the previous sample shows up at once in the index. It also pulses the clear on the same edge as an update, where a design that let the add win would show a nonzero index.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int MUL_CODE_W = 4;
  localparam int MUL_VAL_W  = 5;

  // Doubled multiple; code 0 is the half multiple.
  function automatic logic [MUL_VAL_W-1:0] mul_of(input logic [MUL_CODE_W-1:0] code);
    logic [MUL_VAL_W-1:0] v;
    case (code)
      4'd0:  v = 5'd1;
      4'd11: v = 5'd20;
      4'd12, 4'd13: v = 5'd24;
      4'd14, 4'd15: v = 5'd30;
      default: v = {code, 1'b0};
    endcase
    return v;
  endfunction
endpackage

// File: rtl/fpg_tick_div.sv
module fpg_tick_div #(
  parameter int DIV = 72
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == CNT_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/fpg_incr.sv
module fpg_incr
  import fpg_pkg::*;
#(
  parameter int FNUM_W    = 9,
  parameter int BLK_W     = 3,
  parameter int PRE_SHIFT = 2,
  parameter int RAW_W     = FNUM_W + MUL_VAL_W + (2**BLK_W - 1),
  parameter int INC_W     = RAW_W - PRE_SHIFT
) (
  input  logic [FNUM_W-1:0]     fnum,
  input  logic [BLK_W-1:0]      blk,
  input  logic [MUL_CODE_W-1:0] code,
  output logic [INC_W-1:0]      inc
);
  logic [RAW_W-1:0] base;
  logic [RAW_W-1:0] shifted;

  assign base    = RAW_W'(fnum) * RAW_W'(mul_of(code));
  assign shifted = base << blk;
  assign inc     = INC_W'(shifted >> PRE_SHIFT);
endmodule

// File: rtl/fpg_lfo.sv
module fpg_lfo #(
  parameter int  PH_W     = 16,
  parameter int  TAB_W    = 8,
  parameter int  PM_FRAC  = 8,
  parameter int  VIB_W    = 9,
  parameter int  TREM_W   = 4,
  parameter int  PM_INC   = 8,
  parameter int  AM_INC   = 4,
  parameter real PM_CENTS = 13.75,
  parameter real AM_DB    = 2.4,
  parameter real DB_STEP  = 0.1875
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [VIB_W-1:0]  vib_next,
  output logic [VIB_W-1:0]  vib_q,
  output logic [TREM_W-1:0] trem_q
);
  localparam int  TAB_N = 2**TAB_W;
  localparam real TWO_PI = 6.28318530717958;

  logic [VIB_W-1:0]  pm_rom [TAB_N];
  logic [TREM_W-1:0] am_rom [TAB_N];

  for (genvar i = 0; i < TAB_N; i++) begin : g_rom
    localparam real ANG = TWO_PI * real'(i) / real'(TAB_N);
    assign pm_rom[i] = VIB_W'($rtoi(real'(2**PM_FRAC) * $pow(2.0, PM_CENTS * $sin(ANG) / 1200.0)));
    assign am_rom[i] = TREM_W'($rtoi(AM_DB / 2.0 / DB_STEP * (1.0 + $sin(ANG))));
  end

  logic [PH_W-1:0] pm_ph_q, am_ph_q;
  logic [PH_W-1:0] pm_ph_n, am_ph_n;

  assign pm_ph_n  = pm_ph_q + PH_W'(PM_INC);
  assign am_ph_n  = am_ph_q + PH_W'(AM_INC);
  assign vib_next = pm_rom[pm_ph_n[PH_W-1 -: TAB_W]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_ph_q <= '0;
      am_ph_q <= '0;
      vib_q   <= pm_rom[0];
      trem_q  <= am_rom[0];
    end else if (tick) begin
      pm_ph_q <= pm_ph_n;
      am_ph_q <= am_ph_n;
      vib_q   <= vib_next;
      trem_q  <= am_rom[am_ph_n[PH_W-1 -: TAB_W]];
    end
  end

  assert_lfo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pm_ph_q) && $stable(am_ph_q) && $stable(vib_q) && $stable(trem_q)));
  assert_lfo_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pm_ph_q == $past(pm_ph_q) + PH_W'(PM_INC)));
  assert_trem_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (am_ph_q == $past(am_ph_q) + PH_W'(AM_INC)));
endmodule

// File: rtl/fm_phase_gen.sv
module fm_phase_gen
  import fpg_pkg::*;
#(
  parameter int  CLK_HZ    = 3579545,
  parameter int  DIV       = 72,
  parameter int  FNUM_W    = 9,
  parameter int  BLK_W     = 3,
  parameter int  ACC_W     = 18,
  parameter int  IDX_W     = 9,
  parameter int  LFO_PH_W  = 16,
  parameter int  LFO_TAB_W = 8,
  parameter int  PM_FRAC   = 8,
  parameter int  VIB_W     = 9,
  parameter int  TREM_W    = 4,
  parameter real PM_HZ     = 6.4,
  parameter real AM_HZ     = 3.7,
  parameter real PM_CENTS  = 13.75,
  parameter real AM_DB     = 2.4,
  parameter real DB_STEP   = 0.1875
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FNUM_W-1:0]     fnum_i,
  input  logic [BLK_W-1:0]      block_i,
  input  logic [MUL_CODE_W-1:0] mult_i,
  input  logic                  vib_en_i,
  input  logic                  key_clr_i,
  output logic                  sample_valid_o,
  output logic [IDX_W-1:0]      phase_idx_o,
  output logic [VIB_W-1:0]      vib_factor_o,
  output logic [TREM_W-1:0]     trem_o
);
  localparam int  PRE_SHIFT = 20 - ACC_W;
  localparam int  RAW_W     = FNUM_W + MUL_VAL_W + (2**BLK_W - 1);
  localparam int  INC_W     = RAW_W - PRE_SHIFT;
  localparam int  PROD_W    = INC_W + VIB_W;
  localparam int  SMP_HZ    = CLK_HZ / DIV;
  localparam int  PM_INC    = $rtoi(PM_HZ * real'(2**LFO_PH_W) / real'(SMP_HZ));
  localparam int  AM_INC    = $rtoi(AM_HZ * real'(2**LFO_PH_W) / real'(SMP_HZ));

  logic              tick;
  logic [INC_W-1:0]  inc;
  logic [VIB_W-1:0]  vib_next;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  step;
  logic [ACC_W-1:0]  acc_q;

  fpg_tick_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  fpg_incr #(
    .FNUM_W    (FNUM_W),
    .BLK_W     (BLK_W),
    .PRE_SHIFT (PRE_SHIFT),
    .RAW_W     (RAW_W),
    .INC_W     (INC_W)
  ) u_incr (
    .fnum (fnum_i),
    .blk  (block_i),
    .code (mult_i),
    .inc  (inc)
  );

  fpg_lfo #(
    .PH_W     (LFO_PH_W),
    .TAB_W    (LFO_TAB_W),
    .PM_FRAC  (PM_FRAC),
    .VIB_W    (VIB_W),
    .TREM_W   (TREM_W),
    .PM_INC   (PM_INC),
    .AM_INC   (AM_INC),
    .PM_CENTS (PM_CENTS),
    .AM_DB    (AM_DB),
    .DB_STEP  (DB_STEP)
  ) u_lfo (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .vib_next (vib_next),
    .vib_q    (vib_factor_o),
    .trem_q   (trem_o)
  );

  assign prod = {{VIB_W{1'b0}}, inc} * {{INC_W{1'b0}}, vib_next};
  assign step = vib_en_i ? ACC_W'(prod >> PM_FRAC) : ACC_W'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n)         acc_q <= '0;
    else if (key_clr_i) acc_q <= '0;
    else if (tick)      acc_q <= acc_q + step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sample_valid_o <= 1'b0;
    else        sample_valid_o <= tick;
  end

  assign phase_idx_o = acc_q[ACC_W-1 -: IDX_W];

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_clr_i |=> (phase_idx_o == '0));
  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !key_clr_i) |=> $stable(acc_q));
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sample_valid_o);
  assert_valid_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !sample_valid_o);
endmodule

// File: tb/fm_phase_gen_tb_top.sv
module fm_phase_gen_tb_top;
  localparam int  CLK_PERIOD = 10;
  localparam int  DIV_TB     = 6;
  localparam int  CLK_HZ_TB  = 49716 * DIV_TB;
  localparam int  PM_STEP    = 8;
  localparam int  AM_STEP    = 4;
  localparam real TWO_PI     = 6.28318530717958;
  localparam int  NVEC       = 8;
  // {fnum, octave, code, vib, updates}
  localparam logic [24:0] VEC [NVEC] = '{
    {9'd1,   3'd0, 4'd0,  1'b0, 8'd4},
    {9'd511, 3'd7, 4'd15, 1'b0, 8'd6},
    {9'd300, 3'd4, 4'd1,  1'b0, 8'd5},
    {9'd300, 3'd4, 4'd11, 1'b0, 8'd5},
    {9'd64,  3'd5, 4'd13, 1'b0, 8'd4},
    {9'd128, 3'd3, 4'd5,  1'b1, 8'd8},
    {9'd511, 3'd7, 4'd14, 1'b1, 8'd8},
    {9'd257, 3'd2, 4'd0,  1'b1, 8'd5}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] fnum = '0;
  logic [2:0] blk = '0;
  logic [3:0] code = '0;
  logic       vib = 1'b0;
  logic       kclr = 1'b0;
  logic       valid;
  logic [8:0] idx;
  logic [8:0] vfac;
  logic [3:0] trem;

  int n_chk = 0;
  int n_bad = 0;
  int m_acc = 0;
  int m_pm = 0;
  int m_am = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_phase_gen #(.CLK_HZ(CLK_HZ_TB), .DIV(DIV_TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .fnum_i(fnum), .block_i(blk), .mult_i(code),
    .vib_en_i(vib), .key_clr_i(kclr), .sample_valid_o(valid),
    .phase_idx_o(idx), .vib_factor_o(vfac), .trem_o(trem)
  );

  function automatic int pm_tab(int k);
    return $rtoi(256.0 * $pow(2.0, 13.75 * $sin(TWO_PI * real'(k) / 256.0) / 1200.0));
  endfunction

  function automatic int am_tab(int k);
    return $rtoi(2.4 / 2.0 / 0.1875 * (1.0 + $sin(TWO_PI * real'(k) / 256.0)));
  endfunction

  function automatic int mul_val(int c);
    int t [16] = '{1, 2, 4, 6, 8, 10, 12, 14, 16, 18, 20, 20, 24, 24, 30, 30};
    return t[c];
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 4 * DIV_TB && !valid; i++) @(negedge clk);
    if (!valid) begin
      n_bad++;
      $display("FAIL R2: actual no sample strobe expected one within %0d cycles", 4 * DIV_TB);
    end
  endtask

  // Advance the reference model by one update, using the inputs held now.
  task automatic model_update(bit clear_at_tick);
    int inc, f, st;
    m_pm = (m_pm + PM_STEP) % 65536;
    m_am = (m_am + AM_STEP) % 65536;
    f = pm_tab(m_pm >> 8);
    inc = ((int'(fnum) * mul_val(int'(code))) << blk) >> 2;
    st = vib ? ((inc * f) >> 8) : inc;
    m_acc = clear_at_tick ? 0 : (m_acc + st) % (1 << 18);
  endtask

  task automatic check_sample(string req);
    chk(req, int'(idx), m_acc >> 9);
    chk("R6", int'(vfac), pm_tab(m_pm >> 8));
    chk("R7", int'(trem), am_tab(m_am >> 8));
  endtask

  task automatic next_sample(string req);
    @(negedge clk);
    wait_valid();
    model_update(1'b0);
    check_sample(req);
  endtask

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(idx), 0);
    chk("R1", int'(vfac), 256);
    chk("R1", int'(trem), 6);
    chk("R1", int'(valid), 0);
    rst_n = 1'b1;
    chk("R1", int'(idx), 0);
    // R2: first strobe DIV cycles after release
    gap = 0;
    for (int i = 0; i < 4 * DIV_TB && !valid; i++) begin
      @(negedge clk);
      gap++;
    end
    chk("R2", gap, DIV_TB);
    model_update(1'b0);
    check_sample("R2");
    @(negedge clk);
    chk("R2", int'(valid), 0);
    gap = 1;
    while (!valid && gap < 4 * DIV_TB) begin
      @(negedge clk);
      gap++;
    end
    chk("R2", gap, DIV_TB);
    model_update(1'b0);
    check_sample("R2");

    // Vector table: R3, R4, R5, R8
    for (int v = 0; v < NVEC; v++) begin
      {fnum, blk, code, vib} = VEC[v][24:8];
      kclr = 1'b1;
      @(negedge clk);
      kclr = 1'b0;
      m_acc = 0;
      chk("R9", int'(idx), 0);
      for (int t = 0; t < int'(VEC[v][7:0]); t++)
        next_sample(vib ? "R5" : (v < 5 ? "R3" : "R4"));
    end

    // R9: clear on the same edge as an update
    fnum = 9'd400; blk = 3'd6; code = 4'd9; vib = 1'b0;
    next_sample("R4");
    next_sample("R8");
    repeat (DIV_TB - 1) @(negedge clk);
    kclr = 1'b1;
    @(negedge clk);
    kclr = 1'b0;
    chk("R2", int'(valid), 1);
    model_update(1'b1);
    check_sample("R9");
    next_sample("R9");

    // R10: inputs changed between updates have no effect until the next update
    next_sample("R4");
    fnum = 9'd17; code = 4'd3; blk = 3'd1;
    @(negedge clk);
    @(negedge clk);
    chk("R10", int'(idx), m_acc >> 9);
    chk("R10", int'(vfac), pm_tab(m_pm >> 8));
    fnum = 9'd400; blk = 3'd6; code = 4'd9;
    next_sample("R10");

    // LFO sweep past the vibrato peak with vibrato applied: R5, R6, R7
    fnum = 9'd511; blk = 3'd7; code = 4'd15; vib = 1'b1;
    for (int t = 0; t < 2600; t++) next_sample("R5");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual run not finished expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule